// File: doc/BRIEF.md
# Six-State Instruction Timing Sequencer

This block is the control unit of a minimal accumulator machine. It steps a one-hot ring of six timing states. The first three states form a fixed fetch. The last three execute the instruction whose 4-bit opcode sits in the upper half of the instruction register. In every state it drives a 12-line control word to the datapath: the program counter, the address register, the memory, the instruction register, the accumulator, the B register, the adder/subtracter and the output register.

Every instruction takes exactly six clock cycles. States with nothing to do drive the idle word. The halt instruction freezes the ring in its fourth state, raises a halt flag and forces the idle word until reset.

The reset input is asynchronous and active low. A two-stage synchronizer releases it, so the ring leaves its first state on the third rising edge after reset is released.

Top module: `sap_sequencer`

## Requirements
- R1: While reset is held, and for two rising edges after it is released, the block stays in T1: the control word is the T1 word and `halt` is low.
- R2: T1 drives `pc_drive`=1 and `addr_load_n`=0. T2 drives `pc_inc`=1. T3 drives `mem_drive_n`=0 and `ir_load_n`=0. All other lines hold their idle level in these states.
- R3: Opcode 0x0 (load) drives `ir_drive`=1 with `addr_load_n`=0 in T4, and `mem_drive_n`=0 with `acc_load_n`=0 in T5. T6 drives the idle word.
- R4: Opcode 0x1 (add) drives `ir_drive`=1 with `addr_load_n`=0 in T4, `mem_drive_n`=0 with `b_load_n`=0 in T5, and `alu_drive`=1 with `acc_load_n`=0 and `alu_sub`=0 in T6.
- R5: Opcode 0x2 (subtract) drives the same words as R4, except that `alu_sub`=1 in T6.
- R6: Opcode 0xE (output) drives `acc_drive`=1 with `out_load_n`=0 in T4. T5 and T6 drive the idle word.
- R7: Opcode 0xF seen in T4 raises `halt` in that cycle. From then on the ring stays in T4, the control word is idle and `halt` stays high, whatever the opcode does, until reset.
- R8: Any other opcode value drives the idle word in T4, T5 and T6, and the sequence then continues with T1.
- R9: With no halt, the ring advances one state per clock, and T6 is followed by T1, which gives a period of six cycles.
- R10: The control word bit positions are fixed as follows. Bit 11 is `pc_inc`, 10 `pc_drive`, 9 `addr_load_n`, 8 `mem_drive_n`, 7 `ir_load_n`, 6 `ir_drive`, 5 `acc_load_n`, 4 `acc_drive`, 3 `alu_sub`, 2 `alu_drive`, 1 `b_load_n` and 0 `out_load_n`. The idle word is 0x3A3. At most one bus source (`pc_drive`, `mem_drive_n` low, `ir_drive`, `acc_drive`, `alu_drive`) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| opcode | input | 4 | Upper nibble of the instruction register |
| ctrl_word | output | 12 | Control lines to the datapath; positions listed in R10 |
| halt | output | 1 | High once a halt opcode has been seen in T4 |

## Verification
The bench sends a stream of instructions in which each defined opcode appears several times, in varied neighbours. This separates the execute words of load, add, subtract and output, and shows whether the subtract line is confined to the subtract instruction's T6. Undefined opcodes are mixed in to show that they fall through to idle states without breaking the six-cycle rhythm. A halt opcode is followed by opcode changes while frozen, which shows the freeze is sticky rather than decoded on each cycle. Reset is then applied in the middle of an instruction and the stream is restarted, which exercises the synchronizer delay and the clearing of the halt state.

// File: rtl/sap_seq_pkg.sv
package sap_seq_pkg;
  localparam int SEQ_STATES = 6;
  localparam int OP_W       = 4;
  localparam int CW_W       = 12;

  // control word bit positions
  localparam int CW_PC_INC      = 11;
  localparam int CW_PC_DRIVE    = 10;
  localparam int CW_ADDR_LOAD_N = 9;
  localparam int CW_MEM_DRIVE_N = 8;
  localparam int CW_IR_LOAD_N   = 7;
  localparam int CW_IR_DRIVE    = 6;
  localparam int CW_ACC_LOAD_N  = 5;
  localparam int CW_ACC_DRIVE   = 4;
  localparam int CW_ALU_SUB     = 3;
  localparam int CW_ALU_DRIVE   = 2;
  localparam int CW_B_LOAD_N    = 1;
  localparam int CW_OUT_LOAD_N  = 0;

  // idle word: every active-low line at its inactive (high) level
  localparam logic [CW_W-1:0] CW_IDLE =
      (CW_W'(1) << CW_ADDR_LOAD_N) | (CW_W'(1) << CW_MEM_DRIVE_N) |
      (CW_W'(1) << CW_IR_LOAD_N)   | (CW_W'(1) << CW_ACC_LOAD_N)  |
      (CW_W'(1) << CW_B_LOAD_N)    | (CW_W'(1) << CW_OUT_LOAD_N);

  localparam logic [OP_W-1:0] OPC_LOAD = 4'h0;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OPC_OUT  = 4'hE;
  localparam logic [OP_W-1:0] OPC_HALT = 4'hF;

  typedef enum logic [2:0] {
    INS_LOAD,
    INS_ADD,
    INS_SUB,
    INS_OUT,
    INS_HALT,
    INS_NOP
  } ins_e;
endpackage

// File: rtl/sap_ring_timer.sv
module sap_ring_timer #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [N-1:0] state
);
  localparam logic [N-1:0] FIRST = N'(1);

  logic [N-1:0] state_nxt;

  // rotate by one position: the last state wraps to the first
  assign state_nxt[0] = state[N-1];
  for (genvar i = 1; i < N; i++) begin : g_rot
    assign state_nxt[i] = state[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FIRST;
    end else if (adv) begin
      state <= state_nxt;
    end
  end
endmodule

// File: rtl/sap_op_decode.sv
module sap_op_decode
  import sap_seq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ins_e            ins
);
  always_comb begin
    unique case (opcode)
      OPC_LOAD: ins = INS_LOAD;
      OPC_ADD:  ins = INS_ADD;
      OPC_SUB:  ins = INS_SUB;
      OPC_OUT:  ins = INS_OUT;
      OPC_HALT: ins = INS_HALT;
      default:  ins = INS_NOP;
    endcase
  end
endmodule

// File: rtl/sap_ctrl_encode.sv
module sap_ctrl_encode
  import sap_seq_pkg::*;
(
  input  logic [SEQ_STATES-1:0] state,
  input  ins_e                  ins,
  input  logic                  frozen,
  output logic [CW_W-1:0]       cw
);
  always_comb begin
    cw = CW_IDLE;
    if (!frozen) begin
      // fetch: identical for every instruction
      if (state[0]) begin
        cw[CW_PC_DRIVE]    = 1'b1;
        cw[CW_ADDR_LOAD_N] = 1'b0;
      end
      if (state[1]) begin
        cw[CW_PC_INC] = 1'b1;
      end
      if (state[2]) begin
        cw[CW_MEM_DRIVE_N] = 1'b0;
        cw[CW_IR_LOAD_N]   = 1'b0;
      end
      // execute
      if (state[3]) begin
        if (ins == INS_LOAD || ins == INS_ADD || ins == INS_SUB) begin
          cw[CW_IR_DRIVE]    = 1'b1;
          cw[CW_ADDR_LOAD_N] = 1'b0;
        end else if (ins == INS_OUT) begin
          cw[CW_ACC_DRIVE]  = 1'b1;
          cw[CW_OUT_LOAD_N] = 1'b0;
        end
      end
      if (state[4]) begin
        if (ins == INS_LOAD) begin
          cw[CW_MEM_DRIVE_N] = 1'b0;
          cw[CW_ACC_LOAD_N]  = 1'b0;
        end else if (ins == INS_ADD || ins == INS_SUB) begin
          cw[CW_MEM_DRIVE_N] = 1'b0;
          cw[CW_B_LOAD_N]    = 1'b0;
        end
      end
      if (state[5]) begin
        if (ins == INS_ADD || ins == INS_SUB) begin
          cw[CW_ALU_DRIVE]  = 1'b1;
          cw[CW_ACC_LOAD_N] = 1'b0;
          cw[CW_ALU_SUB]    = (ins == INS_SUB);
        end
      end
    end
  end
endmodule

// File: rtl/sap_sequencer.sv
module sap_sequencer
  import sap_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic [CW_W-1:0] ctrl_word,
  output logic            halt
);
  localparam int EXEC_FIRST = 3;  // index of T4 in the ring

  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic [SEQ_STATES-1:0] state_oh;
  ins_e                  ins;
  logic                  halt_now;
  logic                  halted_q;
  logic                  halted_nxt;
  logic                  ring_adv;

  sap_op_decode u_dec (
    .opcode (opcode),
    .ins    (ins)
  );

  assign halt_now = state_oh[EXEC_FIRST] && (ins == INS_HALT);
  assign halt     = halt_now || halted_q;
  assign ring_adv = !halt;

  sap_ring_timer #(.N(SEQ_STATES)) u_ring (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (ring_adv),
    .state (state_oh)
  );

  // sticky halt: next-state and register processes
  always_comb begin
    halted_nxt = halted_q || halt_now;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      halted_q <= 1'b0;
    end else begin
      halted_q <= halted_nxt;
    end
  end

  sap_ctrl_encode u_enc (
    .state  (state_oh),
    .ins    (ins),
    .frozen (halt),
    .cw     (ctrl_word)
  );
endmodule

module sap_sequencer_chk
  import sap_seq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [SEQ_STATES-1:0] state_oh,
  input logic [CW_W-1:0]       ctrl_word,
  input logic                  halt
);
  // R9
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot(state_oh));

  // R9
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_oh[SEQ_STATES-1] && !halt) |=> state_oh[0]);

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt |=> (halt && $stable(state_oh) && $stable(ctrl_word)));

  // R2
  pc_inc_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_word[CW_PC_INC] |=> !ctrl_word[CW_PC_INC]);

  // R4
  alu_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_word[CW_ALU_DRIVE] |-> !ctrl_word[CW_ACC_LOAD_N]);

  // R10
  one_bus_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ctrl_word[CW_PC_DRIVE], !ctrl_word[CW_MEM_DRIVE_N],
              ctrl_word[CW_IR_DRIVE], ctrl_word[CW_ACC_DRIVE],
              ctrl_word[CW_ALU_DRIVE]}));
endmodule

bind sap_sequencer sap_sequencer_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .state_oh   (state_oh),
  .ctrl_word  (ctrl_word),
  .halt       (halt)
);

// File: tb/sim_sap_sequencer.sv
module sim_sap_sequencer;
  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [11:0] ctrl_word;
  logic        halt;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  sap_sequencer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .halt      (halt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int t        = 1;   // timing state 1..6
  bit hlt      = 0;
  int sync_cnt = 0;
  int prev_t   = 1;

  always @(posedge clk) begin
    prev_t = t;
    if (!rst_n) begin
      t = 1; hlt = 0; sync_cnt = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else if (hlt || (t == 4 && opcode == 4'hF)) begin
      hlt = 1;
    end else begin
      t = (t == 6) ? 1 : t + 1;
    end
  end

  function automatic logic [11:0] ref_word(int ts, logic [3:0] op, bit frz);
    logic [11:0] w;
    w = 12'h3A3;
    if (frz) return w;
    case (ts)
      1: begin w[10] = 1'b1; w[9] = 1'b0; end
      2: w[11] = 1'b1;
      3: begin w[8] = 1'b0; w[7] = 1'b0; end
      4: if (op == 4'h0 || op == 4'h1 || op == 4'h2) begin
           w[6] = 1'b1; w[9] = 1'b0;
         end else if (op == 4'hE) begin
           w[4] = 1'b1; w[0] = 1'b0;
         end
      5: if (op == 4'h0) begin
           w[8] = 1'b0; w[5] = 1'b0;
         end else if (op == 4'h1 || op == 4'h2) begin
           w[8] = 1'b0; w[1] = 1'b0;
         end
      6: if (op == 4'h1 || op == 4'h2) begin
           w[2] = 1'b1; w[5] = 1'b0; w[3] = (op == 4'h2);
         end
      default: ;
    endcase
    return w;
  endfunction

  function automatic string tag(bit in_rst, int ts, int pts, logic [3:0] op, bit frz);
    if (in_rst) return "R1";
    if (frz) return "R7";
    if (ts == 1 && pts == 6) return "R9";
    if (ts <= 3) return "R2";
    case (op)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2: return "R5";
      4'hE: return "R6";
      default: return "R8";
    endcase
  endfunction

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit in_rst;
      bit frz;
      logic [11:0] exp_w;
      bit exp_h;
      string rq;
      int srcs;
      in_rst = !rst_n || sync_cnt < 2;
      frz    = !in_rst && (hlt || (t == 4 && opcode == 4'hF));
      exp_w  = in_rst ? ref_word(1, opcode, 0) : ref_word(t, opcode, frz);
      exp_h  = frz;
      rq     = tag(in_rst, t, prev_t, opcode, frz);
      checks++;
      if (ctrl_word !== exp_w) begin
        errors++;
        $display("FAIL %s ctrl_word actual=%h expected=%h (T%0d op=%h)",
                 rq, ctrl_word, exp_w, t, opcode);
      end
      checks++;
      if (halt !== exp_h) begin
        errors++;
        $display("FAIL %s halt actual=%b expected=%b (T%0d op=%h)",
                 rq, halt, exp_h, t, opcode);
      end
      // R10: at most one bus source
      srcs = int'(ctrl_word[10]) + int'(!ctrl_word[8]) + int'(ctrl_word[6]) +
             int'(ctrl_word[4]) + int'(ctrl_word[2]);
      checks++;
      if (srcs > 1) begin
        errors++;
        $display("FAIL R10 bus sources actual=%0d expected<=1", srcs);
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [3:0] prog_a [16] = '{4'h0, 4'h1, 4'h2, 4'hE, 4'h3, 4'h2, 4'h1, 4'h7,
                              4'h0, 4'hE, 4'hD, 4'h2, 4'h2, 4'h1, 4'hE, 4'hF};
  logic [3:0] prog_b [8]  = '{4'h1, 4'hE, 4'h0, 4'hC, 4'h2, 4'hE, 4'h4, 4'hF};

  task automatic run_prog(input int which, input int n);
    int idx = 0;
    while (idx < n) begin
      @(posedge clk); #2;
      if (rst_n && sync_cnt == 2 && t == 1 && !hlt) begin
        opcode = (which == 0) ? prog_a[idx] : prog_b[idx];
        idx++;
      end
    end
    repeat (8) @(posedge clk);
  endtask

  task automatic do_reset(input int cycles);
    @(posedge clk); #2;
    rst_n = 1'b0;
    repeat (cycles) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 4'h0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run_prog(0, 16);                 // R3..R6, R8, R9, ends in halt (R7)
    // R7: opcode changes while frozen must not release the halt
    foreach (prog_b[i]) begin
      @(posedge clk); #2 opcode = prog_b[i];
    end
    repeat (4) @(posedge clk);
    do_reset(2);                     // R1
    run_prog(1, 5);
    // R1: reset in the middle of an instruction
    repeat (3) @(posedge clk);
    do_reset(1);
    opcode = 4'h2;
    repeat (20) @(posedge clk);
    run_prog(1, 8);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule